// File: doc/BRIEF.md
# Prescaled Countdown Interrupt Timer

This block is a 32-bit down-counter that raises a one-cycle interrupt event when it expires. A prescaler divides the base clock by a power of two, and the counter moves once on each prescaled tick. The divide setting comes from a compact three-bit code. A control word selects one-shot or periodic operation and a mask. It also holds the vector and the delivery mode that the event carries.

Software reaches the block through a flat register port. The port has a write strobe, a two-bit register select and a combinational read-back, and covers four registers: control, divide, initial count and current count. Writing the initial count reloads the counter and realigns the prescaler, so the countdown starts at the moment of the write. A synchronous soft-init input returns the registers to their reset values without a full reset.

Top module: `cnt_timer`

## Requirements
- R1: The divide register keeps only bits 3, 1 and 0 of the written value and reads back as `wr_data & 4'hB`. The code v = {bit3, bit1, bit0} gives shift = (v+1) mod 8. The counter moves once every 2^shift base clocks, so code 4'hB divides by 1, code 0 divides by 2 and code 3 divides by 16.
- R2: Register selects are 0 for control, 1 for divide, 2 for initial count and 3 for current count. Reads return the stored value of each register, and select 3 returns the live counter.
- R3: In the control word, bit 17 selects periodic mode and bit 16 masks the event. Bits 7:0 give the vector and bits 10:8 give the delivery mode. Each event presents the vector and the mode that are current when it fires.
- R4: A write of the initial count loads the counter with the written value and restarts the prescaler. The k-th decrement then lands k·2^shift clocks after the write edge, even if a countdown was already running.
- R5: In one-shot mode, the counter drops by one per tick and stays at 0. A single event fires on the tick that brings it from 1 to 0, which is N·2^shift clocks after a load of N.
- R6: In periodic mode, the counter runs from N down to 0 and then reloads N. An event fires at each reload, so events come every (N+1)·2^shift clocks.
- R7: A masked timer never fires, but it keeps counting. A periodic timer with an initial count of 0 never fires, and neither does a one-shot load of 0.
- R8: After reset or soft-init, the control word reads 32'h0001_0000 and the divide, initial-count and current-count registers read 0. No event is raised.
- R9: Writing the control word or the divide register does not reload the counter or restart the prescaler. The new setting acts from the next tick.
- R10: Writes to the current-count select are ignored.
- R11: The event output is high for exactly one clock per expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soft_init | input | 1 | Synchronous return of all registers to reset values |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Combinational read data |
| evt_valid | output | 1 | One-cycle expiry event |
| evt_vector | output | 8 | Vector carried by the event |
| evt_mode | output | 3 | Delivery mode carried by the event |

## Verification
The assertions take reset and soft-init to be synchronous, and they take every input to be steady around the rising edge. Under that assumption, the counter changes only on a tick, a load or a clear, and each event can be traced to the control word of the previous cycle. The bench changes every input on the falling edge and samples outputs there too. It orders its writes so that the divide code and the control word are in place before the initial-count write that starts each measured countdown.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_INIT = 2'd2,
    SEL_CUR  = 2'd3
  } tmr_sel_e;

  localparam int CTRL_PERIODIC_BIT = 17;
  localparam int CTRL_MASK_BIT     = 16;
  localparam int CTRL_MODE_LSB     = 8;
  localparam logic [31:0] CTRL_RESET = 32'h0001_0000;
  localparam logic [3:0]  DIV_KEEP   = 4'hB;

  // Three-bit divide code to prescale shift, wrapping modulo eight.
  function automatic logic [2:0] div_to_shift(input logic [3:0] code);
    logic [2:0] v;
    v = {code[3], code[1], code[0]};
    return v + 3'd1;
  endfunction

  // Low-order ones mask selecting the prescaler bits for a given shift.
  function automatic logic [6:0] shift_mask(input logic [2:0] sh);
    return 7'((8'd1 << sh) - 8'd1);
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_init,
  input  logic              wr_en,
  input  tmr_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [3:0]        div_q,
  output logic [DATA_W-1:0] init_q,
  output logic              init_load
);
  assign init_load = wr_en && (wr_sel == SEL_INIT) && !soft_init;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_init) begin
      ctrl_q <= DATA_W'(CTRL_RESET);
      div_q  <= '0;
      init_q <= '0;
    end else if (wr_en) begin
      unique case (wr_sel)
        SEL_CTRL: ctrl_q <= wr_data;
        SEL_DIV:  div_q  <= wr_data[3:0] & DIV_KEEP;
        SEL_INIT: init_q <= wr_data;
        SEL_CUR:  ; // live count is not writable
      endcase
    end
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import timer_pkg::*;
#(
  parameter int SHIFT_W = 3,
  localparam int PRE_W  = (1 << SHIFT_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] msk;

  assign msk  = PRE_W'(shift_mask(3'(shift)));
  assign tick = ((pre_q & msk) == msk);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             expire
);
  logic at_zero, at_one, step;

  assign at_zero = (cur == '0);
  assign at_one  = (cur == CNT_W'(1));
  assign step    = tick && !load && !clear;
  assign expire  = step && ((at_one && !periodic) ||
                            (at_zero && periodic && (reload_val != '0)));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cur <= '0;
    end else if (load) begin
      cur <= load_val;
    end else if (tick) begin
      if (!at_zero)                            cur <= cur - 1'b1;
      else if (periodic && reload_val != '0)   cur <= reload_val;
    end
  end
endmodule

// File: rtl/cnt_timer.sv
module cnt_timer
  import timer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SHIFT_W = 3,
  parameter int VEC_W   = 8,
  parameter int MODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_init,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [1:0]        rd_sel,
  output logic [CNT_W-1:0]  rd_data,
  output logic              evt_valid,
  output logic [VEC_W-1:0]  evt_vector,
  output logic [MODE_W-1:0] evt_mode
);
  logic [CNT_W-1:0]   ctrl_q, init_q, cur_w;
  logic [3:0]         div_q;
  logic               init_load, tick_w, expire_w;
  logic               periodic_w, masked_w;
  logic [SHIFT_W-1:0] shift_w;

  assign periodic_w = ctrl_q[CTRL_PERIODIC_BIT];
  assign masked_w   = ctrl_q[CTRL_MASK_BIT];
  assign shift_w    = SHIFT_W'(div_to_shift(div_q));

  tmr_regs #(.DATA_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_init(soft_init),
    .wr_en(wr_en), .wr_sel(tmr_sel_e'(wr_sel)), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .div_q(div_q), .init_q(init_q), .init_load(init_load)
  );

  tmr_prescale #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(init_load || soft_init),
    .shift(shift_w), .tick(tick_w)
  );

  tmr_down #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(soft_init),
    .load(init_load), .load_val(wr_data), .reload_val(init_q),
    .tick(tick_w), .periodic(periodic_w),
    .cur(cur_w), .expire(expire_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || soft_init) begin
      evt_valid  <= 1'b0;
      evt_vector <= '0;
      evt_mode   <= '0;
    end else begin
      evt_valid <= expire_w && !masked_w;
      if (expire_w && !masked_w) begin
        evt_vector <= ctrl_q[VEC_W-1:0];
        evt_mode   <= ctrl_q[CTRL_MODE_LSB +: MODE_W];
      end
    end
  end

  always_comb begin
    unique case (tmr_sel_e'(rd_sel))
      SEL_CTRL: rd_data = ctrl_q;
      SEL_DIV:  rd_data = CNT_W'(div_q);
      SEL_INIT: rd_data = init_q;
      SEL_CUR:  rd_data = cur_w;
    endcase
  end
endmodule

// File: rtl/cnt_timer_chk.sv
module cnt_timer_chk #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_init,
  input logic             tick,
  input logic             init_load,
  input logic             periodic,
  input logic             masked,
  input logic [CNT_W-1:0] cur,
  input logic [CNT_W-1:0] init_q,
  input logic [CNT_W-1:0] ctrl_q,
  input logic             evt_valid,
  input logic [VEC_W-1:0] evt_vector
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !init_load && !soft_init) |=> $stable(cur)); // R1

  AST_EVT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !$past(soft_init)) |-> (evt_vector == $past(ctrl_q[VEC_W-1:0]))); // R3

  AST_ONESHOT_STICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && cur == '0 && !init_load && !soft_init) |=> (cur == '0)); // R5

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur != '0 && !init_load && !soft_init) |=> (cur == $past(cur) - 1'b1)); // R5

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && periodic && cur == '0 && !init_load && !soft_init) |=> (cur == $past(init_q))); // R6

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> !evt_valid); // R7

  AST_ZERO_PERIOD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && init_q == '0 && !init_load) |=> !evt_valid); // R7

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid); // R11
endmodule

bind cnt_timer cnt_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_init(soft_init),
  .tick(tick_w), .init_load(init_load), .periodic(periodic_w),
  .masked(masked_w), .cur(cur_w), .init_q(init_q), .ctrl_q(ctrl_q),
  .evt_valid(evt_valid), .evt_vector(evt_vector)
);

// File: tb/test_cnt_timer.sv
module test_cnt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_init = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        evt_valid;
  logic [7:0]  evt_vector;
  logic [2:0]  evt_mode;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  cnt_timer i_cnt_timer (
    .clk(clk), .rst_n(rst_n), .soft_init(soft_init),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .evt_valid(evt_valid), .evt_vector(evt_vector), .evt_mode(evt_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  // Runs n cycles from a falling edge; records first two event indices and count.
  task automatic run(input int n, output int first, output int second, output int cnt,
                     output logic [7:0] vec, output logic [2:0] md);
    first = -1; second = -1; cnt = 0; vec = 0; md = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); @(negedge clk);
      if (evt_valid) begin
        cnt++;
        if (first < 0) begin first = i; vec = evt_vector; md = evt_mode; end
        else if (second < 0) second = i;
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); check("R8", "ctrl after reset", v, 32'h0001_0000);
    rd(2'd1, v); check("R8", "div after reset", v, 0);
    rd(2'd2, v); check("R8", "init after reset", v, 0);
    rd(2'd3, v); check("R8", "cur after reset", v, 0);
    check("R8", "no event after reset", evt_valid, 0);
  endtask

  task automatic t_divide();
    logic [31:0] v; int f, s, c; logic [7:0] vec; logic [2:0] md;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R1", "divide keeps bits 3,1,0", v, 32'hB);
    wr(2'd0, 32'h0000_0342);
    wr(2'd2, 32'd5);
    run(10, f, s, c, vec, md);
    check("R1", "div1 one-shot N=5 fire cycle", f, 5);
    check("R3", "event vector", vec, 8'h42);
    check("R3", "event mode", md, 3);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'd3);
    run(12, f, s, c, vec, md);
    check("R1", "div2 code 0 N=3 fire cycle", f, 6);
    wr(2'd1, 32'h3);
    wr(2'd2, 32'd2);
    run(40, f, s, c, vec, md);
    check("R1", "div16 code 3 N=2 fire cycle", f, 32);
  endtask

  task automatic t_oneshot();
    logic [31:0] v; int f, s, c; logic [7:0] vec; logic [2:0] md;
    wr(2'd1, 32'hB);
    wr(2'd0, 32'h0000_0011);
    wr(2'd2, 32'd4);
    run(60, f, s, c, vec, md);
    check("R5", "one-shot fire cycle", f, 4);
    check("R5", "one-shot event count", c, 1);
    check("R11", "single-cycle event count", c, 1);
    rd(2'd3, v); check("R5", "one-shot stays at zero", v, 0);
    wr(2'd3, 32'h99);
    rd(2'd3, v); check("R10", "current count write ignored", v, 0);
    wr(2'd2, 32'd0);
    run(30, f, s, c, vec, md);
    check("R7", "one-shot zero load silent", c, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v; int f, s, c; logic [7:0] vec; logic [2:0] md;
    wr(2'd1, 32'hB);
    wr(2'd0, 32'h0002_0021);
    wr(2'd2, 32'd3);
    rd(2'd3, v); check("R6", "loaded count visible", v, 3);
    run(1, f, s, c, vec, md);
    rd(2'd3, v); check("R2", "live count read", v, 2);
    run(19, f, s, c, vec, md);
    check("R6", "first wrap", f, 3);
    check("R6", "second wrap", s, 7);
    check("R6", "wraps in window", c, 5);
    wr(2'd2, 32'd0);
    run(40, f, s, c, vec, md);
    check("R7", "periodic zero never fires", c, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v; int f, s, c; logic [7:0] vec; logic [2:0] md;
    wr(2'd1, 32'hB);
    wr(2'd0, 32'h0003_0005);
    wr(2'd2, 32'd2);
    run(30, f, s, c, vec, md);
    check("R7", "masked periodic silent", c, 0);
    wr(2'd0, 32'h0002_0005);
    run(12, f, s, c, vec, md);
    check("R7", "unmasked periodic fires", (c > 0) ? 1 : 0, 1);
    rd(2'd0, v); check("R2", "ctrl read back", v, 32'h0002_0005);
  endtask

  task automatic t_restart();
    logic [31:0] v; int f, s, c; logic [7:0] vec; logic [2:0] md;
    wr(2'd1, 32'hB);
    wr(2'd0, 32'h0000_0007);
    wr(2'd2, 32'd10);
    run(4, f, s, c, vec, md);
    check("R4", "no early event", c, 0);
    wr(2'd2, 32'd3);
    run(10, f, s, c, vec, md);
    check("R4", "reload restarts countdown", f, 3);
    wr(2'd2, 32'd8);
    run(3, f, s, c, vec, md);
    wr(2'd0, 32'h0000_0007);
    rd(2'd3, v); check("R9", "ctrl write keeps count", v, 4);
    run(10, f, s, c, vec, md);
    check("R9", "fire after ctrl write", f, 4);
  endtask

  task automatic t_soft_init();
    logic [31:0] v;
    wr(2'd0, 32'h0002_0077);
    wr(2'd1, 32'h3);
    wr(2'd2, 32'd50);
    soft_init = 1'b1; @(posedge clk); @(negedge clk); soft_init = 1'b0;
    rd(2'd0, v); check("R8", "ctrl after soft-init", v, 32'h0001_0000);
    rd(2'd1, v); check("R8", "div after soft-init", v, 0);
    rd(2'd2, v); check("R8", "init after soft-init", v, 0);
    rd(2'd3, v); check("R8", "cur after soft-init", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_divide();
    t_oneshot();
    t_periodic();
    t_mask();
    t_restart();
    t_soft_init();
    finished = 1;
  end

  initial begin
    while (!finished && cycles < WATCHDOG) begin
      @(posedge clk); cycles++;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule